// File: doc/BRIEF.md
# Auxiliary 64K Bank Mapper

This block translates the addresses of an 8-bit processor with a 64K address space into a 24-bit physical memory address. It also produces a select that says whether the access goes to main or auxiliary memory, and a flag for the I/O page. Several independent switches decide where each part of the CPU map lands. The low page (zero page and stack) and the upper 16K language-card area share one switch. Reads and writes in the 48K middle area each have their own switch. The 4K window at 0xD000 has a second bank that can be chosen instead of the first. Whenever auxiliary memory is selected, an 8-bit bank register picks which of up to 256 expansion banks of 64K stands in as auxiliary memory. Main memory always sits in bank 0.

The CPU sets and clears the switches by writing to eight dedicated addresses at the bottom of the I/O page. One further address loads the bank register from the write data. The translation is combinational from the current address, the direction and the registered switch state. A switch write therefore affects accesses from the next cycle onward.

The address decode sorts every CPU address into one of five region classes. RG_LOWPAGE is 0x0000–0x01FF. RG_MAIN48 is 0x0200–0xBFFF. RG_IO is 0xC000–0xCFFF. RG_LC4K is 0xD000–0xDFFF. RG_LC12K is 0xE000–0xFFFF. The only state transitions are the register updates caused by switch writes, and the return of all switches to their reset values when reset is asserted.

Top module: `aux_bank_mapper`

## Requirements
- R1: After reset, every region maps to main memory, the bank register holds 0 and the 4K window uses its first bank.
- R2: Addresses 0x0000–0x01FF keep their 16-bit offset and go to auxiliary memory for both reads and writes exactly when the low/card switch is set.
- R3: Addresses 0x0200–0xBFFF go to auxiliary memory on a read when the read switch is set and on a write when the write switch is set. The two switches are independent of each other.
- R4: Addresses 0xC000–0xCFFF assert mem_io, never select auxiliary memory, and pass through as {8'h00, cpu_addr}.
- R5: Addresses 0xD000–0xDFFF follow the low/card switch. With the alternate-bank switch clear, the offset is unchanged. With it set, the offset becomes {4'hC, cpu_addr[11:0]}.
- R6: Addresses 0xE000–0xFFFF follow the low/card switch and keep their offset regardless of the alternate-bank switch.
- R7: When auxiliary memory is selected, mem_addr[23:16] equals the bank register. When main memory is selected, mem_addr[23:16] is 0 whatever the bank register holds.
- R8: These write addresses act on the switches: 0xC000 clears read and 0xC001 sets read; 0xC002 clears write and 0xC003 sets write; 0xC004 clears low/card and 0xC005 sets low/card; 0xC006 clears alternate-bank and 0xC007 sets alternate-bank. 0xC008 loads the bank register from cpu_wdata. The new value applies from the next cycle.
- R9: A switch address changes nothing unless cpu_valid and cpu_we are both high. A read or an idle cycle at 0xC000–0xC008 leaves all switches and the bank register as they were.
- R10: The bank register takes all 8 bits of cpu_wdata, so banks 0x00 through 0xFF are all reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | CPU access in this cycle |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| mem_addr | output | 24 | Translated physical address |
| mem_aux | output | 1 | Access goes to auxiliary memory |
| mem_io | output | 1 | Access falls in the I/O page |

## Verification
All three outputs depend only on the current address, the current direction and the switch state, so they are due within the same cycle the address is presented. The bench drives each access on the falling edge and compares the outputs one nanosecond before the next rising edge. A switch write becomes visible one cycle later. The reference model therefore applies each write only after that rising edge, and the following access sees the new value. Back-to-back pairs of a switch write followed by an access to the affected region exercise this one-cycle boundary.

// File: rtl/abm_pkg.sv
package abm_pkg;
    parameter int ADDR_W = 16;
    parameter int BANK_W = 8;
    localparam int PHYS_W = ADDR_W + BANK_W;

    localparam logic [ADDR_W-1:0] LOWPAGE_END = 16'h0200;
    localparam logic [ADDR_W-1:0] IO_BASE     = 16'hC000;
    localparam logic [3:0]        IO_NIB      = 4'hC;
    localparam logic [3:0]        LC4K_NIB    = 4'hD;
    localparam logic [ADDR_W-1:0] SW_BASE     = IO_BASE;
    localparam int                SW_LAST     = 8;

    typedef enum logic [2:0] {
        RG_LOWPAGE,
        RG_MAIN48,
        RG_IO,
        RG_LC4K,
        RG_LC12K
    } region_e;

    typedef struct packed {
        logic              rd_aux;
        logic              wr_aux;
        logic              card_aux;
        logic              lc_alt;
        logic [BANK_W-1:0] bank;
    } sw_t;
endpackage

// File: rtl/abm_switch_regs.sv
module abm_switch_regs
    import abm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] wdata,
    output sw_t               sw_q
);
    localparam int OFS_W = 4;

    logic              hit;
    logic [OFS_W-1:0]  ofs;
    sw_t               sw_d;

    assign ofs = addr[OFS_W-1:0];
    assign hit = wr_stb && (addr[ADDR_W-1:OFS_W] == SW_BASE[ADDR_W-1:OFS_W])
                 && (int'(ofs) <= SW_LAST);

    always_comb begin
        sw_d = sw_q;
        if (hit) begin
            case (ofs)
                4'h0: sw_d.rd_aux   = 1'b0;
                4'h1: sw_d.rd_aux   = 1'b1;
                4'h2: sw_d.wr_aux   = 1'b0;
                4'h3: sw_d.wr_aux   = 1'b1;
                4'h4: sw_d.card_aux = 1'b0;
                4'h5: sw_d.card_aux = 1'b1;
                4'h6: sw_d.lc_alt   = 1'b0;
                4'h7: sw_d.lc_alt   = 1'b1;
                4'h8: sw_d.bank     = wdata;
                default: sw_d = sw_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end
endmodule

// File: rtl/abm_region_decode.sv
module abm_region_decode
    import abm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr < LOWPAGE_END) begin
            region = RG_LOWPAGE;
        end else if (addr < IO_BASE) begin
            region = RG_MAIN48;
        end else begin
            case (addr[ADDR_W-1:ADDR_W-4])
                IO_NIB:   region = RG_IO;
                LC4K_NIB: region = RG_LC4K;
                default:  region = RG_LC12K;
            endcase
        end
    end
endmodule

// File: rtl/abm_translate.sv
module abm_translate
    import abm_pkg::*;
(
    input  region_e           region,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  sw_t               sw,
    output logic [PHYS_W-1:0] phys,
    output logic              aux,
    output logic              io
);
    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs = addr;
        aux = 1'b0;
        io  = 1'b0;
        unique case (region)
            RG_LOWPAGE: aux = sw.card_aux;
            RG_MAIN48:  aux = we ? sw.wr_aux : sw.rd_aux;
            RG_IO:      io  = 1'b1;
            RG_LC4K: begin
                aux = sw.card_aux;
                if (sw.lc_alt) ofs = {IO_NIB, addr[ADDR_W-5:0]};
            end
            RG_LC12K:   aux = sw.card_aux;
            default:    aux = 1'b0;
        endcase
        phys = {(aux ? sw.bank : {BANK_W{1'b0}}), ofs};
    end
endmodule

// File: rtl/aux_bank_mapper.sv
module aux_bank_mapper
    import abm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [23:0]       mem_addr,
    output logic              mem_aux,
    output logic              mem_io
);
    sw_t     sw_q;
    region_e region;

    abm_switch_regs u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (cpu_valid && cpu_we),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .sw_q   (sw_q)
    );

    abm_region_decode u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    abm_translate u_xl (
        .region (region),
        .addr   (cpu_addr),
        .we     (cpu_we),
        .sw     (sw_q),
        .phys   (mem_addr),
        .aux    (mem_aux),
        .io     (mem_io)
    );
endmodule

// File: rtl/abm_checker.sv
module abm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_valid,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic [23:0] mem_addr,
    input logic        mem_aux,
    input logic        mem_io,
    input logic [7:0]  bank_q
);
    p_io_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'hC) |-> (mem_io && !mem_aux && mem_addr == {8'h00, cpu_addr}));

    p_main_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_aux |-> (mem_addr[23:16] == 8'h00));

    p_aux_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_aux |-> (mem_addr[23:16] == bank_q));

    p_lowpage_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h0200) |-> (mem_addr[15:0] == cpu_addr && !mem_io));

    p_lc4k_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'hD) |-> (mem_addr[11:0] == cpu_addr[11:0]
                                       && (mem_addr[15:12] == 4'hC || mem_addr[15:12] == 4'hD)));

    p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_we && cpu_addr == 16'hC008) |=> (bank_q == $past(cpu_wdata)));

    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_valid && cpu_we && cpu_addr == 16'hC008) |=> $stable(bank_q));
endmodule

bind aux_bank_mapper abm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .mem_addr  (mem_addr),
    .mem_aux   (mem_aux),
    .mem_io    (mem_io),
    .bank_q    (sw_q.bank)
);

// File: tb/sim_aux_bank_mapper.sv
module sim_aux_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [23:0] mem_addr;
    logic        mem_aux;
    logic        mem_io;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit m_rd, m_wr, m_card, m_alt;
    int m_bank;

    always #5 clk = ~clk;

    aux_bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_addr(mem_addr), .mem_aux(mem_aux), .mem_io(mem_io)
    );

    function automatic string req_of(int a);
        if (a < 'h200) return "R2";
        if (a < 'hC000) return "R3";
        if (a < 'hD000) return "R4";
        if (a < 'hE000) return "R5";
        return "R6";
    endfunction

    task automatic step(input int a, input bit we, input bit vld, input int wd, input string tag);
        int off;
        bit eaux, eio;
        logic [23:0] eaddr;
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_we = we; cpu_valid = vld; cpu_wdata = wd[7:0];
        #4;
        off = a; eio = 0;
        if (a < 'h200) eaux = m_card;
        else if (a < 'hC000) eaux = we ? m_wr : m_rd;
        else if (a < 'hD000) begin eaux = 0; eio = 1; end
        else if (a < 'hE000) begin eaux = m_card; if (m_alt) off = a - 'h1000; end
        else eaux = m_card;
        eaddr = {(eaux ? m_bank[7:0] : 8'h00), off[15:0]};
        n_cmp++;
        if (mem_addr !== eaddr || mem_aux !== eaux || mem_io !== eio) begin
            n_bad++;
            $display("FAIL %s addr=%h we=%0d: got addr=%h aux=%0d io=%0d, expected addr=%h aux=%0d io=%0d",
                     tag, a[15:0], we, mem_addr, mem_aux, mem_io, eaddr, eaux, eio);
        end
        @(posedge clk);
        if (vld && we) begin
            case (a)
                'hC000: m_rd = 0;   'hC001: m_rd = 1;
                'hC002: m_wr = 0;   'hC003: m_wr = 1;
                'hC004: m_card = 0; 'hC005: m_card = 1;
                'hC006: m_alt = 0;  'hC007: m_alt = 1;
                'hC008: m_bank = wd & 'hFF;
                default: ;
            endcase
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_rd = 0; m_wr = 0; m_card = 0; m_alt = 0; m_bank = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state everywhere
        step('h0100, 0, 1, 0, "R1");
        step('h4000, 1, 1, 0, "R1");
        step('hD123, 0, 1, 0, "R1");
        step('hF000, 1, 1, 0, "R1");
        // R10 / R7: bank load but switches main -> upper byte still 0
        step('hC008, 1, 1, 'hFF, "R10");
        step('h3000, 0, 1, 0, "R7");
        // R3: read aux only, write stays main
        step('hC001, 1, 1, 0, "R8");
        step('h3000, 0, 1, 0, "R3");
        step('h3000, 1, 1, 0, "R3");
        step('hC003, 1, 1, 0, "R8");
        step('hC000, 1, 1, 0, "R8");
        step('hBFFF, 1, 1, 0, "R3");
        step('h0200, 0, 1, 0, "R3");
        // R2 / R5 / R6: low/card switch
        step('hC005, 1, 1, 0, "R8");
        step('h01FF, 1, 1, 0, "R2");
        step('h0000, 0, 1, 0, "R2");
        step('hDABC, 0, 1, 0, "R5");
        step('hC007, 1, 1, 0, "R8");
        step('hDABC, 1, 1, 0, "R5");
        step('hD000, 0, 1, 0, "R5");
        step('hFFFF, 0, 1, 0, "R6");
        step('hE000, 1, 1, 0, "R6");
        // R4: I/O passthrough even with aux selected
        step('hC0F0, 0, 1, 0, "R4");
        step('hCFFF, 1, 1, 0, "R4");
        // R9: read / invalid writes to switch addresses ignored
        step('hC004, 0, 1, 0, "R9");
        step('hC008, 1, 0, 'h12, "R9");
        step('hC008, 0, 1, 'h34, "R9");
        step('h0080, 0, 1, 0, "R9");
        step('hC006, 1, 0, 0, "R9");
        step('hD555, 0, 1, 0, "R9");
        // R10: low and mid banks
        step('hC008, 1, 1, 'h00, "R10");
        step('hE800, 0, 1, 0, "R10");
        step('hC008, 1, 1, 'h80, "R10");
        step('hE800, 0, 1, 0, "R10");
        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            int a;
            bit w, v;
            if ($urandom_range(3) == 0) a = 'hC000 + $urandom_range(9);
            else a = $urandom_range(16'hFFFF);
            w = $urandom_range(1);
            v = ($urandom_range(4) != 0);
            step(a, w, v, $urandom_range(255), (a >= 'hC000 && a <= 'hC009) ? "R8" : req_of(a));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule